// File: doc/BRIEF.md
# Vector Iota and Index Generator

This block fills a destination vector register group with one integer per element and hands each result to the register file through an element-write port, at most one element per cycle. In iota mode, element i gets the number of source mask bits that are set at active positions below i. That is an exclusive prefix count. In index mode, element i gets its own index.

Element width is selectable at 8, 16, 32 or 64 bits. An element counts as active when the unmasked flag is high, or when its bit in the v0 mask is set. Inactive elements are never written, so the register file keeps their old contents. A start pulse captures all operands. One cycle after the last element, the block pulses done together with a vector-state-dirty strobe and a vstart-clear strobe. Iota refuses a nonzero vstart: in that case it raises an illegal-start pulse instead of running.

Top module: `vec_iota_index_gen`

## Requirements
- R1: In iota mode (`mode`=0) each written element i carries the count of positions j < i for which j is active and `src_mask[j]`=1.
- R2: A source bit at an inactive position adds nothing to the iota count.
- R3: A start in iota mode with `vstart` != 0 pulses `illegal_start` for one cycle, in the cycle after the start edge. It produces no write, no `done` and no strobes.
- R4: In index mode (`mode`=1) the element with index i is written with value i. Elements run from `vstart` to `vl`-1 in ascending order. The element at position begin+k appears k+1 cycles after the start edge, where begin is `vstart` in index mode and 0 in iota mode.
- R5: An element is written only when it is active, meaning `unmasked`=1 or `v0_mask[i]`=1. Inactive elements produce no `wr_valid`.
- R6: When `unmasked`=1, every element in range is active and `v0_mask` has no effect.
- R7: `done`, `vs_dirty` and `vstart_clr` pulse together for one cycle, vl-begin+1 cycles after the start edge, with `wr_valid` low in that cycle.
- R8: `wr_sew` encodes the element width: 0 for 8 bits, 1 for 16, 2 for 32, 3 for 64. `wr_data` is the value truncated to that width, with the upper bits zero.
- R9: If `vl`=0, or if `vstart` >= `vl` in index mode, `done` pulses one cycle after the start edge and nothing is written.
- R10: After reset, `wr_valid`, `done`, `illegal_start`, `vs_dirty` and `vstart_clr` are all low.
- R11: A `start` pulse that arrives while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; captures all operands |
| mode | input | 1 | 0 = iota, 1 = index |
| unmasked | input | 1 | Treat every element as active |
| v0_mask | input | MAX_VL | Per-element active bits |
| src_mask | input | MAX_VL | Source mask counted in iota mode |
| vl | input | LW | Vector length |
| vstart | input | LW | First element (index mode) |
| sew | input | 2 | Element width code |
| wr_valid | output | 1 | Element write strobe |
| wr_idx | output | LW | Element index being written |
| wr_data | output | 64 | Element value, truncated to SEW |
| wr_sew | output | 2 | Element width code of the write |
| done | output | 1 | Operation finished |
| vs_dirty | output | 1 | Vector state modified strobe |
| vstart_clr | output | 1 | Clear vstart strobe |
| illegal_start | output | 1 | Iota started with nonzero vstart |

## Verification
If the running count went wrong, every later iota write would carry a shifted value. The fault would show on `wr_data` at the first active element after it. If the element pointer or the active test went wrong, writes would be missing, extra or out of order on `wr_idx`. A length error would move the `done` pulse away from its expected cycle. The stimulus mixes random masks, lengths and widths with directed edge cases, so each of these faults shows up within the operation that causes it.

// File: rtl/vec_iota_index_gen.sv
module vec_iota_index_gen #(
  parameter int MAX_VL = 64,
  localparam int LW = $clog2(MAX_VL + 1),
  localparam int IW = (MAX_VL > 1) ? $clog2(MAX_VL) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic              unmasked,
  input  logic [MAX_VL-1:0] v0_mask,
  input  logic [MAX_VL-1:0] src_mask,
  input  logic [LW-1:0]     vl,
  input  logic [LW-1:0]     vstart,
  input  logic [1:0]        sew,
  output logic              wr_valid,
  output logic [LW-1:0]     wr_idx,
  output logic [63:0]       wr_data,
  output logic [1:0]        wr_sew,
  output logic              done,
  output logic              vs_dirty,
  output logic              vstart_clr,
  output logic              illegal_start
);

  logic              busy, mode_q, all_act_q;
  logic [MAX_VL-1:0] act_q, src_q;
  logic [LW-1:0]     vl_q, idx, cnt;
  logic [1:0]        sew_q;

  wire [IW-1:0] pos    = idx[IW-1:0];
  wire          in_rng = idx < vl_q;
  wire          active = all_act_q | act_q[pos];
  wire          hit    = active & src_q[pos];
  wire [63:0]   raw    = {{(64-LW){1'b0}}, mode_q ? idx : cnt};

  function automatic logic [63:0] clip(input logic [63:0] v, input logic [1:0] w);
    case (w)
      2'd0:    clip = {56'd0, v[7:0]};
      2'd1:    clip = {48'd0, v[15:0]};
      2'd2:    clip = {32'd0, v[31:0]};
      default: clip = v;
    endcase
  endfunction

  assign vs_dirty   = done;
  assign vstart_clr = done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy          <= 1'b0;
      mode_q        <= 1'b0;
      all_act_q     <= 1'b0;
      act_q         <= '0;
      src_q         <= '0;
      vl_q          <= '0;
      idx           <= '0;
      cnt           <= '0;
      sew_q         <= 2'd0;
      wr_valid      <= 1'b0;
      wr_idx        <= '0;
      wr_data       <= '0;
      wr_sew        <= 2'd0;
      done          <= 1'b0;
      illegal_start <= 1'b0;
    end else begin
      wr_valid      <= 1'b0;
      done          <= 1'b0;
      illegal_start <= 1'b0;
      if (!busy) begin
        if (start) begin
          if (!mode && vstart != '0) begin
            illegal_start <= 1'b1;
          end else begin
            busy      <= 1'b1;
            mode_q    <= mode;
            all_act_q <= unmasked;
            act_q     <= v0_mask;
            src_q     <= src_mask;
            vl_q      <= vl;
            sew_q     <= sew;
            idx       <= mode ? vstart : '0;
            cnt       <= '0;
          end
        end
      end else if (in_rng) begin
        wr_valid <= active;
        wr_idx   <= idx;
        wr_data  <= clip(raw, sew_q);
        wr_sew   <= sew_q;
        idx      <= idx + 1'b1;
        cnt      <= cnt + {{(LW-1){1'b0}}, hit};
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && $past(wr_valid) |-> wr_idx > $past(wr_idx));

  assert_trunc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_sew == 2'd0 |-> wr_data[63:8] == 56'd0);

  assert_no_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_start |-> !wr_valid && !done && !busy);

  assert_quiet_after_R3: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_start |=> !wr_valid && !done);

  assert_done_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_valid && !busy);

  assert_iota_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !mode_q && wr_idx == '0 |-> wr_data == 64'd0);

  assert_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_idx < vl_q);

endmodule

// File: tb/vec_iota_index_gen_bench.sv
module vec_iota_index_gen_bench;
  localparam int N  = 320;
  localparam int LW = $clog2(N + 1);

  logic clk = 0, rst_n = 0, start = 0, mode = 0, unmasked = 0;
  logic [N-1:0] v0_mask = '0, src_mask = '0;
  logic [LW-1:0] vl = '0, vstart = '0;
  logic [1:0] sew = 0;
  logic wr_valid, done, vs_dirty, vstart_clr, illegal_start;
  logic [LW-1:0] wr_idx;
  logic [63:0] wr_data;
  logic [1:0] wr_sew;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  vec_iota_index_gen #(.MAX_VL(N)) u_vec_iota_index_gen (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .unmasked(unmasked),
    .v0_mask(v0_mask), .src_mask(src_mask), .vl(vl), .vstart(vstart), .sew(sew),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data), .wr_sew(wr_sew),
    .done(done), .vs_dirty(vs_dirty), .vstart_clr(vstart_clr),
    .illegal_start(illegal_start));

  task automatic chk(input bit ok, input string req, input longint unsigned act,
                     input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic longint unsigned clip(input longint unsigned v, input logic [1:0] w);
    case (w)
      2'd0: return v & 64'hFF;
      2'd1: return v & 64'hFFFF;
      2'd2: return v & 64'hFFFF_FFFF;
      default: return v;
    endcase
  endfunction

  task automatic run_op(input bit md, input bit vmf, input logic [N-1:0] v0,
                        input logic [N-1:0] src, input int len_v, input int vs,
                        input logic [1:0] sw, input bit poke);
    int exp_i[$];
    longint unsigned exp_v[$];
    int cnt = 0, first, span, got = 0, c = 0;
    bit fin = 0, bad;
    string vreq;
    bad   = !md && vs != 0;
    first = md ? vs : 0;
    span  = (len_v > first) ? len_v - first : 0;
    vreq  = md ? "R4 R8" : "R1 R2 R8";
    for (int i = first; i < len_v; i++) begin
      bit act = vmf | v0[i];
      if (act) begin
        exp_i.push_back(i);
        exp_v.push_back(clip(md ? longint'(i) : longint'(cnt), sw));
      end
      if (!md && act && src[i]) cnt++;
    end
    @(negedge clk);
    mode = md; unmasked = vmf; v0_mask = v0; src_mask = src;
    vl = LW'(len_v); vstart = LW'(vs); sew = sw; start = 1;
    @(negedge clk);
    start = 0;
    if (bad) begin
      chk(illegal_start == 1'b1, "R3 illegal_start", illegal_start, 1);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!wr_valid && !done && !vs_dirty, "R3 quiet", {wr_valid, done, vs_dirty}, 0);
      end
      return;
    end
    chk(illegal_start == 1'b0, "R3 no illegal", illegal_start, 0);
    while (!fin && c < N + 10) begin
      @(negedge clk);
      c++;
      if (poke) begin
        if (c == 3) begin mode = 0; vstart = 7; vl = 1; start = 1; end
        else start = 0;
        if (illegal_start) chk(0, "R11 start while busy", 1, 0);
      end
      if (wr_valid) begin
        if (got < exp_i.size()) begin
          chk(int'(wr_idx) == exp_i[got], "R4 R5 index", wr_idx, exp_i[got]);
          chk(wr_data == exp_v[got], vreq, wr_data, exp_v[got]);
          chk(wr_sew == sw, "R8 wr_sew", wr_sew, sw);
          chk(c == exp_i[got] - first + 1, "R4 timing", c, exp_i[got] - first + 1);
        end else chk(0, "R5 extra write", wr_idx, 0);
        got++;
      end
      if (done) begin
        fin = 1;
        chk(c == span + 1, span == 0 ? "R9 done timing" : "R7 done timing", c, span + 1);
        chk(vs_dirty && vstart_clr, "R7 strobes", {vs_dirty, vstart_clr}, 3);
        chk(!wr_valid, "R7 no write with done", wr_valid, 0);
      end
    end
    start = 0;
    chk(fin, "R7 done seen", fin, 1);
    chk(got == exp_i.size(), vmf ? "R6 write count" : "R5 write count", got, exp_i.size());
    @(negedge clk);
    chk(!done && !vs_dirty && !vstart_clr, "R7 single pulse", {done, vs_dirty}, 0);
  endtask

  function automatic logic [N-1:0] rnd_vec(input int dens);
    logic [N-1:0] v;
    for (int i = 0; i < N; i++) v[i] = ($urandom % 100) < dens;
    return v;
  endfunction

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk(!wr_valid && !done && !illegal_start && !vs_dirty && !vstart_clr,
        "R10 reset outputs", {wr_valid, done, illegal_start}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!wr_valid && !done && !illegal_start, "R10 after release", {wr_valid, done}, 0);

    // iota, all active, all sources set: element i gets i (R1, R6)
    run_op(0, 1, '0, '1, 20, 0, 2'd3, 0);
    // iota with v0 masking; inactive source bits must not count (R2, R5)
    run_op(0, 0, {N/4{4'b0101}}, '1, 40, 0, 2'd2, 0);
    // unmasked ignores v0 = all zero (R6)
    run_op(1, 1, '0, '0, 16, 3, 2'd1, 0);
    // iota with nonzero vstart is refused (R3)
    run_op(0, 1, '1, '1, 10, 4, 2'd3, 0);
    // empty cases (R9)
    run_op(0, 1, '1, '1, 0, 0, 2'd3, 0);
    run_op(1, 1, '1, '1, 5, 5, 2'd3, 0);
    run_op(1, 1, '1, '1, 5, 9, 2'd3, 0);
    // index truncation at 8 bits past 255 (R8)
    run_op(1, 1, '0, '0, 300, 250, 2'd0, 0);
    // iota count past 255 at 8 bits (R8)
    run_op(0, 1, '0, '1, 300, 0, 2'd0, 0);
    // start while busy is ignored (R11)
    run_op(1, 0, rnd_vec(60), '0, 30, 2, 2'd2, 1);
    run_op(0, 0, rnd_vec(50), rnd_vec(50), 30, 0, 2'd3, 1);
    // random mix
    for (int t = 0; t < 40; t++) begin
      bit md = $urandom % 2;
      int lv = $urandom % (N + 1);
      int vs = md ? int'($urandom % (lv + 2)) : 0;
      run_op(md, ($urandom % 4) == 0, rnd_vec($urandom % 101), rnd_vec($urandom % 101),
             lv, vs, 2'($urandom % 4), 0);
    end
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule